// File: doc/BRIEF.md
# Upper Memory Region Map Controller

This block decides what a given 24-bit physical address resolves to in the upper part of the first megabyte and in the top megabyte of the 16 MB space. It holds three control bits, which software sets through byte-wide I/O writes. The first is a diagnostic overlay that covers the system BIOS window. The second selects whether the BIOS window is backed by ROM or by shadow RAM. The third is an alias hole, which makes 0xF00000–0xFFFFFF mirror video memory and the upper 1 MB area instead of ordinary RAM.

A lookup address is presented on one port. The block returns a region descriptor for it on the same cycle. The descriptor is a source code plus an offset into that source. The memories themselves sit outside the block. The diagnostic overlay takes priority over the BIOS ROM/RAM choice. When the hole is on, pages of the top megabyte that do not hold video planes are resolved exactly as their image in the first megabyte would be.

Top module: `upper_mem_map`

## Requirements
- R1: After a synchronous active-low reset the overlay is on, BIOS RAM select is clear and the hole is on.
- R2: Writing 0x00, 0x10 or 0x18 to port 0x43D turns the overlay on. While it is on, 0xE8000–0xF7FFF reports source EMPTY (code 8) with offset 0, and 0xF8000–0xFFFFF reports source DIAG (code 2) with offset address−0xF8000.
- R3: Writing 0x02 or 0x12 to port 0x43D turns the overlay off. Any other value written to 0x43D leaves the overlay unchanged. Writes to other ports, and cycles without a write strobe, leave the overlay unchanged.
- R4: With the overlay off and BIOS RAM select clear, 0xE8000–0xFFFFF reports source BIOS (code 1) with offset address−0xE8000.
- R5: A write to port 0x53D loads BIOS RAM select from bit 1 and ignores every other bit. With the overlay off and the select set, 0xE8000–0xFFFFF reports source RAM (code 0) with offset equal to the address.
- R6: While the overlay is on, BIOS RAM select has no visible effect on the map. Its value appears once the overlay is turned off.
- R7: A write to port 0x43B with bit 2 set turns the hole off, and a write with bit 2 clear turns it on. With the hole off, 0xF00000–0xFFFFFF reports RAM with offset equal to the address.
- R8: With the hole on, the top megabyte reports sources by local offset L = address & 0xFFFFF:
  - L below 0xA0000 is GFX (code 3), offset L.
  - 0xA0000–0xA7FFF is TEXT (code 4), offset L−0xA0000.
  - 0xA8000–0xAFFFF is PLANE_A (code 5), offset L−0xA8000.
  - 0xB0000–0xBFFFF is PLANE_B (code 6), offset L−0xB0000.
  - 0xE0000–0xE7FFF is PLANE_E (code 7), offset L−0xE0000.
- R9: With the hole on, 0xFC0000–0xFDFFFF and 0xFE8000–0xFFFFFF resolve as address & 0xFFFFF would, including the current overlay and BIOS RAM state.
- R10: A read of port 0x43B returns 0x00 with the hole on and 0x04 with it off. A read of port 0x63D always returns 0x04. Both assert the read-hit output. Reads of other ports, or cycles without a read strobe, give hit 0 and data 0x00.
- R11: Every address outside the BIOS window and outside an active hole reports RAM with offset equal to the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr_en | input | 1 | I/O write strobe |
| io_rd_en | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| io_rd_hit | output | 1 | Read address belongs to this block |
| lookup_addr | input | 24 | Physical address to resolve |
| desc_kind | output | 4 | Source code of the region |
| desc_offset | output | 24 | Offset into the source |

## Verification
The lookup is probed at the ends and the interior of every window. This separates off-by-one boundary faults from wrong base subtraction. Each overlay code, accepted and rejected, is written in turn so that each acceptance and each rejection is seen on its own. BIOS RAM select is changed under the overlay and then revealed, which proves the overlay has priority. Mirror pages of the hole are looked up in both overlay states, so a mirror that bypasses the BIOS logic is caught.

// File: rtl/upper_mem_map_pkg.sv
// Package: shared source codes for the upper memory region map.
// Assumes a 24-bit physical space and a 1 MB low region.
package upper_mem_map_pkg;

    typedef enum logic [3:0] {
        SRC_RAM     = 4'd0,
        SRC_BIOS    = 4'd1,
        SRC_DIAG    = 4'd2,
        SRC_GFX     = 4'd3,
        SRC_TEXT    = 4'd4,
        SRC_PLANE_A = 4'd5,
        SRC_PLANE_B = 4'd6,
        SRC_PLANE_E = 4'd7,
        SRC_EMPTY   = 4'd8
    } src_e;

endpackage

// File: rtl/upr_ctrl_regs.sv
// Module: control state and I/O port decode.
// Holds the overlay, BIOS RAM select and hole bits. Write-side decode is registered.
// Read data is combinational. Assumes single-byte port accesses.
module upr_ctrl_regs #(
    parameter int          IO_W        = 16,
    parameter int          DATA_W      = 8,
    parameter logic [15:0] OVL_PORT    = 16'h043D,
    parameter logic [15:0] SHADOW_PORT = 16'h053D,
    parameter logic [15:0] HOLE_PORT   = 16'h043B,
    parameter logic [15:0] STATUS_PORT = 16'h063D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr_en,
    input  logic              io_rd_en,
    input  logic [IO_W-1:0]   io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rd_hit,
    output logic              overlay_on,
    output logic              bios_ram_sel,
    output logic              hole_on
);

    localparam logic [DATA_W-1:0] HOLE_OFF_CODE = DATA_W'(8'h04);
    localparam int                SHADOW_BIT    = 1;
    localparam int                HOLE_BIT      = 2;

    // Purpose: update the three control bits from port writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overlay_on   <= 1'b1;
            bios_ram_sel <= 1'b0;
            hole_on      <= 1'b1;
        end else if (io_wr_en) begin
            if (io_addr == IO_W'(OVL_PORT)) begin
                case (io_wdata)
                    DATA_W'(8'h00), DATA_W'(8'h10), DATA_W'(8'h18): overlay_on <= 1'b1;
                    DATA_W'(8'h02), DATA_W'(8'h12):                 overlay_on <= 1'b0;
                    default:                                        overlay_on <= overlay_on;
                endcase
            end
            if (io_addr == IO_W'(SHADOW_PORT)) begin
                bios_ram_sel <= io_wdata[SHADOW_BIT];
            end
            if (io_addr == IO_W'(HOLE_PORT)) begin
                hole_on <= !io_wdata[HOLE_BIT];
            end
        end
    end

    // Purpose: answer reads of the hole state port and the fixed status port.
    always_comb begin
        io_rdata  = '0;
        io_rd_hit = 1'b0;
        if (io_rd_en && io_addr == IO_W'(HOLE_PORT)) begin
            io_rd_hit = 1'b1;
            io_rdata  = hole_on ? '0 : HOLE_OFF_CODE;
        end else if (io_rd_en && io_addr == IO_W'(STATUS_PORT)) begin
            io_rd_hit = 1'b1;
            io_rdata  = HOLE_OFF_CODE;
        end
    end

    assert_overlay_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_en && io_addr == IO_W'(OVL_PORT) &&
         (io_wdata == DATA_W'(8'h02) || io_wdata == DATA_W'(8'h12))) |=> !overlay_on);

    assert_overlay_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr_en || io_addr != IO_W'(OVL_PORT)) |=> $stable(overlay_on));

    assert_shadow_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_en && io_addr == IO_W'(SHADOW_PORT)) |=> (bios_ram_sel == $past(io_wdata[SHADOW_BIT])));

    assert_hole_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_en && io_addr == IO_W'(HOLE_PORT)) |=> (hole_on != $past(io_wdata[HOLE_BIT])));

endmodule

// File: rtl/upr_hole_map.sv
// Module: top-megabyte alias hole decode.
// With the hole on, it claims the video plane windows of the top megabyte.
// It folds the mirror pages down into the first megabyte for the BIOS window decode.
// Purely combinational. Assumes ADDR_W - LOW_W upper bits select the megabyte.
module upr_hole_map
    import upper_mem_map_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LOW_W  = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              hole_on,
    output logic              hole_hit,
    output src_e              hole_kind,
    output logic [ADDR_W-1:0] hole_offset,
    output logic [ADDR_W-1:0] fwd_addr
);

    localparam logic [LOW_W-1:0] TEXT_BASE   = LOW_W'(20'hA0000);
    localparam logic [LOW_W-1:0] PLANE_A_LO  = LOW_W'(20'hA8000);
    localparam logic [LOW_W-1:0] PLANE_B_LO  = LOW_W'(20'hB0000);
    localparam logic [LOW_W-1:0] MIRROR_LO   = LOW_W'(20'hC0000);
    localparam logic [LOW_W-1:0] PLANE_E_LO  = LOW_W'(20'hE0000);
    localparam logic [LOW_W-1:0] MIRROR_HI   = LOW_W'(20'hE8000);

    logic [LOW_W-1:0] low;
    logic             in_top;

    // Purpose: classify a top-megabyte address into a plane window or a mirror page.
    always_comb begin
        low         = addr[LOW_W-1:0];
        in_top      = hole_on && (addr[ADDR_W-1:LOW_W] == '1);
        hole_hit    = 1'b0;
        hole_kind   = SRC_RAM;
        hole_offset = '0;
        fwd_addr    = addr;
        if (in_top) begin
            fwd_addr = ADDR_W'(low);
            if (low < TEXT_BASE) begin
                hole_hit    = 1'b1;
                hole_kind   = SRC_GFX;
                hole_offset = ADDR_W'(low);
            end else if (low < PLANE_A_LO) begin
                hole_hit    = 1'b1;
                hole_kind   = SRC_TEXT;
                hole_offset = ADDR_W'(low - TEXT_BASE);
            end else if (low < PLANE_B_LO) begin
                hole_hit    = 1'b1;
                hole_kind   = SRC_PLANE_A;
                hole_offset = ADDR_W'(low - PLANE_A_LO);
            end else if (low < MIRROR_LO) begin
                hole_hit    = 1'b1;
                hole_kind   = SRC_PLANE_B;
                hole_offset = ADDR_W'(low - PLANE_B_LO);
            end else if (low >= PLANE_E_LO && low < MIRROR_HI) begin
                hole_hit    = 1'b1;
                hole_kind   = SRC_PLANE_E;
                hole_offset = ADDR_W'(low - PLANE_E_LO);
            end
        end
    end

endmodule

// File: rtl/upr_bios_map.sv
// Module: BIOS window decode for the first megabyte.
// Resolves the diagnostic overlay, BIOS ROM or shadow RAM. Everything else is RAM at the
// same address. Purely combinational. The overlay has priority over the RAM select.
module upr_bios_map
    import upper_mem_map_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LOW_W  = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              overlay_on,
    input  logic              bios_ram_sel,
    output src_e              kind,
    output logic [ADDR_W-1:0] offset
);

    localparam logic [LOW_W-1:0] BIOS_LO = LOW_W'(20'hE8000);
    localparam logic [LOW_W-1:0] DIAG_LO = LOW_W'(20'hF8000);

    logic [LOW_W-1:0] low;
    logic             in_window;

    // Purpose: pick the BIOS window source from overlay and RAM select.
    always_comb begin
        low       = addr[LOW_W-1:0];
        in_window = (addr[ADDR_W-1:LOW_W] == '0) && (low >= BIOS_LO);
        kind      = SRC_RAM;
        offset    = addr;
        if (in_window) begin
            if (overlay_on) begin
                if (low >= DIAG_LO) begin
                    kind   = SRC_DIAG;
                    offset = ADDR_W'(low - DIAG_LO);
                end else begin
                    kind   = SRC_EMPTY;
                    offset = '0;
                end
            end else if (!bios_ram_sel) begin
                kind   = SRC_BIOS;
                offset = ADDR_W'(low - BIOS_LO);
            end
        end
    end

endmodule

// File: rtl/upper_mem_map.sv
// Module: top of the upper memory region map controller.
// Combines the control registers, the hole decode and the BIOS window decode.
// The result is one region descriptor per lookup address, on the same cycle.
module upper_mem_map
    import upper_mem_map_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LOW_W  = 20,
    parameter int IO_W   = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr_en,
    input  logic              io_rd_en,
    input  logic [IO_W-1:0]   io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rd_hit,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic [3:0]        desc_kind,
    output logic [ADDR_W-1:0] desc_offset
);

    localparam logic [15:0] STATUS_PORT = 16'h063D;

    logic              overlay_on;
    logic              bios_ram_sel;
    logic              hole_on;
    logic              hole_hit;
    src_e              hole_kind;
    src_e              bios_kind;
    logic [ADDR_W-1:0] hole_offset;
    logic [ADDR_W-1:0] bios_offset;
    logic [ADDR_W-1:0] fwd_addr;

    upr_ctrl_regs #(
        .IO_W       (IO_W),
        .DATA_W     (DATA_W),
        .STATUS_PORT(STATUS_PORT)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_wr_en    (io_wr_en),
        .io_rd_en    (io_rd_en),
        .io_addr     (io_addr),
        .io_wdata    (io_wdata),
        .io_rdata    (io_rdata),
        .io_rd_hit   (io_rd_hit),
        .overlay_on  (overlay_on),
        .bios_ram_sel(bios_ram_sel),
        .hole_on     (hole_on)
    );

    upr_hole_map #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) i_hole (
        .addr       (lookup_addr),
        .hole_on    (hole_on),
        .hole_hit   (hole_hit),
        .hole_kind  (hole_kind),
        .hole_offset(hole_offset),
        .fwd_addr   (fwd_addr)
    );

    upr_bios_map #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) i_bios (
        .addr        (fwd_addr),
        .overlay_on  (overlay_on),
        .bios_ram_sel(bios_ram_sel),
        .kind        (bios_kind),
        .offset      (bios_offset)
    );

    // Purpose: video planes of an active hole win, otherwise the BIOS window decode answers.
    always_comb begin
        desc_kind   = hole_hit ? hole_kind   : bios_kind;
        desc_offset = hole_hit ? hole_offset : bios_offset;
    end

    assert_hole_off_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hole_on && lookup_addr[ADDR_W-1:LOW_W] == '1) |->
        (desc_kind == 4'(SRC_RAM) && desc_offset == lookup_addr));

    assert_overlay_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overlay_on && lookup_addr[ADDR_W-1:LOW_W] == '0 &&
         lookup_addr[LOW_W-1:0] >= LOW_W'(20'hE8000)) |->
        (desc_kind == 4'(SRC_DIAG) || desc_kind == 4'(SRC_EMPTY)));

    assert_status_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd_en && io_addr == IO_W'(STATUS_PORT)) |->
        (io_rd_hit && io_rdata == DATA_W'(8'h04)));

endmodule

// File: tb/test_upper_mem_map.sv
// Directed bench for the upper memory region map controller.
module test_upper_mem_map;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr_en = 1'b0;
    logic        io_rd_en = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rd_hit;
    logic [23:0] lookup_addr = '0;
    logic [3:0]  desc_kind;
    logic [23:0] desc_offset;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    localparam logic [3:0] K_RAM = 4'd0, K_BIOS = 4'd1, K_DIAG = 4'd2, K_GFX = 4'd3,
                           K_TEXT = 4'd4, K_PA = 4'd5, K_PB = 4'd6, K_PE = 4'd7,
                           K_EMPTY = 4'd8;

    always #4 clk = ~clk;

    upper_mem_map i_upper_mem_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_wr_en   (io_wr_en),
        .io_rd_en   (io_rd_en),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .io_rd_hit  (io_rd_hit),
        .lookup_addr(lookup_addr),
        .desc_kind  (desc_kind),
        .desc_offset(desc_offset)
    );

    task automatic port_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr_en = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr_en = 1'b0; io_addr = '0; io_wdata = '0;
    endtask

    task automatic check_map(input logic [23:0] a, input logic [3:0] ek,
                             input logic [23:0] eo, input string req);
        lookup_addr = a;
        #1;
        n_checks++;
        if (desc_kind !== ek || desc_offset !== eo) begin
            n_fails++;
            $display("FAIL %s addr=%h actual kind=%0d off=%h expected kind=%0d off=%h",
                     req, a, desc_kind, desc_offset, ek, eo);
        end
    endtask

    task automatic check_read(input logic [15:0] a, input logic en, input logic eh,
                              input logic [7:0] ed, input string req);
        @(negedge clk);
        io_rd_en = en; io_addr = a;
        #1;
        n_checks++;
        if (io_rd_hit !== eh || io_rdata !== ed) begin
            n_fails++;
            $display("FAIL %s port=%h actual hit=%0b data=%h expected hit=%0b data=%h",
                     req, a, io_rd_hit, io_rdata, eh, ed);
        end
        io_rd_en = 1'b0; io_addr = '0;
    endtask

    task automatic t_reset;
        check_map(24'h0F8000, K_DIAG, 24'h0, "R1");
        check_map(24'h0FFFFF, K_DIAG, 24'h7FFF, "R1");
        check_map(24'h0E8000, K_EMPTY, 24'h0, "R1");
        check_read(16'h043B, 1'b1, 1'b1, 8'h00, "R1");
    endtask

    task automatic t_overlay_codes;
        port_write(16'h043D, 8'h02);
        check_map(24'h0E8000, K_BIOS, 24'h0, "R3");
        port_write(16'h043D, 8'h10);
        check_map(24'h0F7FFF, K_EMPTY, 24'h0, "R2");
        port_write(16'h043D, 8'h12);
        check_map(24'h0F8000, K_BIOS, 24'h10000, "R3");
        port_write(16'h043D, 8'h18);
        check_map(24'h0F8010, K_DIAG, 24'h10, "R2");
        port_write(16'h043D, 8'h02);
        port_write(16'h043D, 8'h00);
        check_map(24'h0E8000, K_EMPTY, 24'h0, "R2");
        port_write(16'h043D, 8'h02);
        port_write(16'h043D, 8'h05);
        check_map(24'h0E8000, K_BIOS, 24'h0, "R3 ignored value");
        port_write(16'h043C, 8'h00);
        check_map(24'h0E8000, K_BIOS, 24'h0, "R3 other port");
        port_write(16'h043D, 8'h18);
        port_write(16'h043D, 8'hFF);
        check_map(24'h0E8000, K_EMPTY, 24'h0, "R3 ignored value");
    endtask

    task automatic t_bios_rom;
        port_write(16'h043D, 8'h02);
        check_map(24'h0E8000, K_BIOS, 24'h0, "R4");
        check_map(24'h0F7FFF, K_BIOS, 24'hFFFF, "R4");
        check_map(24'h0FFFFF, K_BIOS, 24'h17FFF, "R4");
        check_map(24'h0E7FFF, K_RAM, 24'h0E7FFF, "R11");
    endtask

    task automatic t_shadow;
        port_write(16'h043D, 8'h00);
        port_write(16'h053D, 8'h02);
        check_map(24'h0F8000, K_DIAG, 24'h0, "R6");
        check_map(24'h0E8000, K_EMPTY, 24'h0, "R6");
        port_write(16'h043D, 8'h02);
        check_map(24'h0E8000, K_RAM, 24'h0E8000, "R6 revealed");
        check_map(24'h0FFFFF, K_RAM, 24'h0FFFFF, "R5");
        port_write(16'h053D, 8'hFD);
        check_map(24'h0F0000, K_BIOS, 24'h8000, "R5 bit1 clear");
        port_write(16'h053D, 8'h02);
        check_map(24'h0F0000, K_RAM, 24'h0F0000, "R5");
        port_write(16'h053D, 8'h00);
    endtask

    task automatic t_hole;
        port_write(16'h043B, 8'h00);
        check_map(24'hF00000, K_GFX, 24'h0, "R8");
        check_map(24'hF9FFFF, K_GFX, 24'h9FFFF, "R8");
        check_map(24'hFA0000, K_TEXT, 24'h0, "R8");
        check_map(24'hFA8004, K_PA, 24'h4, "R8");
        check_map(24'hFBFFFF, K_PB, 24'hFFFF, "R8");
        check_map(24'hFE0010, K_PE, 24'h10, "R8");
        check_map(24'hFE7FFF, K_PE, 24'h7FFF, "R8");
        check_map(24'hFC1234, K_RAM, 24'h0C1234, "R9");
        port_write(16'h043D, 8'h02);
        check_map(24'hFFFFF0, K_BIOS, 24'h17FF0, "R9 overlay off");
        port_write(16'h043D, 8'h00);
        check_map(24'hFFFFF0, K_DIAG, 24'h7FF0, "R9 overlay on");
        check_map(24'hFE8000, K_EMPTY, 24'h0, "R9 overlay on");
        port_write(16'h043B, 8'h04);
        check_read(16'h043B, 1'b1, 1'b1, 8'h04, "R10");
        check_map(24'hF00000, K_RAM, 24'hF00000, "R7");
        check_map(24'hFFFFF0, K_RAM, 24'hFFFFF0, "R7");
        port_write(16'h043B, 8'hFB);
        check_read(16'h043B, 1'b1, 1'b1, 8'h00, "R10");
        check_map(24'hFA0000, K_TEXT, 24'h0, "R7 back on");
    endtask

    task automatic t_reads;
        check_read(16'h063D, 1'b1, 1'b1, 8'h04, "R10");
        check_read(16'h0123, 1'b1, 1'b0, 8'h00, "R10 other port");
        check_read(16'h043B, 1'b0, 1'b0, 8'h00, "R10 no strobe");
    endtask

    task automatic t_plain_ram;
        check_map(24'h000000, K_RAM, 24'h000000, "R11");
        check_map(24'h100000, K_RAM, 24'h100000, "R11");
        check_map(24'hEFFFFF, K_RAM, 24'hEFFFFF, "R11");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_overlay_codes;
        t_bios_rom;
        t_shadow;
        t_hole;
        t_reads;
        t_plain_ram;
        finish_run;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run;
    end

endmodule